// File: doc/BRIEF.md
# Polynomial-Basis Finite Field Multiplier

This block multiplies two elements of the binary extension field GF(2^m), each given as m polynomial-basis coordinates, and returns their product reduced modulo a fixed irreducible polynomial. It is purely combinational, with no clock. The field width and the polynomial are elaboration-time parameters.

The product is built in two stages. The first stage is an AND-XOR inner-product network. It forms the unreduced carry-less product and splits it into two parts. The low part holds the m coefficients of x^0 to x^(m-1). The high part holds the m-1 coefficients of x^m to x^(2m-2). The second stage folds the high part onto the low part through a constant reduction matrix. Each row of that matrix is x^(m+j) mod P(x), computed during elaboration.

Both intermediate vectors are brought out as ports. A neighbouring check-bit predictor can therefore take its parity terms straight from them, without recomputing the product.

Top module: `gfmul_pb`

## Requirements
- R1: For every operand pair, `prodOut` equals opA·opB mod P(x). Bit i of each operand and of the result is the coefficient of x^i. P(x) is x^WIDTH plus the terms set in parameter POLY.
- R2: `lowVec[i]` is the XOR of opA[j]&opB[k] over all j+k = i, for i in 0..WIDTH-1.
- R3: `highVec[j]` is the XOR of opA[i]&opB[k] over all i+k = WIDTH+j, for j in 0..WIDTH-2.
- R4: `prodOut` equals `lowVec` XOR the XOR, over every j with highVec[j] set, of (x^(WIDTH+j) mod P(x)).
- R5: If either operand is zero, `prodOut`, `lowVec` and `highVec` are all zero.
- R6: If one operand is the field identity (value 1), `prodOut` equals the other operand and `highVec` is zero.
- R7: The outputs follow an input change within the same time step, with no clock edge involved.
- R8: Swapping the two operands changes none of the outputs.
- R9: With WIDTH=3 and P(x)=x^3+x+1 (POLY=3'b011): c2=d2^e1, c1=d1^e0^e1 and c0=d0^e0, where d is `lowVec` and e is `highVec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand, polynomial-basis coordinates |
| opB | input | WIDTH | Second operand, polynomial-basis coordinates |
| prodOut | output | WIDTH | Reduced product |
| lowVec | output | WIDTH | Unreduced coefficients x^0..x^(WIDTH-1) |
| highVec | output | WIDTH-1 | Unreduced coefficients x^WIDTH..x^(2WIDTH-2) |

## Verification
The embedded assertions are evaluated whenever the inputs settle. They check the zero-operand rule, the identity-operand rule, and that an empty high vector leaves the low vector unchanged through the fold. Exact product values need the bench: it compares every operand pair against a shift-and-reduce model at WIDTH 8 and WIDTH 3. The bench also shows that the outputs do not depend on operand order, that the intermediate vectors fold as stated, and that the outputs settle without a clock.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int MAXW = 32;

  // x^power mod P(x), where P(x) = x^width + polyLow; result held in MAXW bits
  function automatic logic [MAXW-1:0] xPowMod(int width, logic [MAXW-1:0] polyLow, int power);
    logic [MAXW:0] acc;
    acc = '0;
    acc[0] = 1'b1;
    for (int s = 0; s < power; s++) begin
      acc = acc << 1;
      if (acc[width]) begin
        acc[width] = 1'b0;
        acc = acc ^ {1'b0, polyLow};
      end
    end
    return acc[MAXW-1:0];
  endfunction
endpackage

// File: rtl/gfm_inner.sv
module gfm_inner #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] lowVec,
  output logic [WIDTH-2:0] highVec
);
  localparam int FULLW = 2 * WIDTH - 1;

  logic [FULLW-1:0] fullProd;

  // one inner product per coefficient of the unreduced product
  for (genvar k = 0; k < FULLW; k++) begin : g_coef
    always_comb begin
      fullProd[k] = 1'b0;
      for (int i = 0; i < WIDTH; i++) begin
        if (k - i >= 0 && k - i < WIDTH) begin
          fullProd[k] = fullProd[k] ^ (opA[i] & opB[k-i]);
        end
      end
    end
  end

  assign lowVec  = fullProd[WIDTH-1:0];
  assign highVec = fullProd[FULLW-1:WIDTH];

  always_comb begin
    if (!$isunknown({opA, opB, lowVec, highVec}) && opB == WIDTH'(1)) begin
      // R6
      unit_inner_chk: assert (lowVec == opA && highVec == '0);
    end
  end
endmodule

// File: rtl/gfm_reduce.sv
module gfm_reduce #(
  parameter int              WIDTH = 8,
  parameter logic [WIDTH-1:0] POLY = 8'h1B
) (
  input  logic [WIDTH-1:0] lowVec,
  input  logic [WIDTH-2:0] highVec,
  output logic [WIDTH-1:0] prodOut
);
  logic [WIDTH-1:0] qRow [WIDTH-1];

  // row j of the reduction matrix: x^(WIDTH+j) mod P(x)
  for (genvar j = 0; j < WIDTH - 1; j++) begin : g_row
    localparam logic [gfm_pkg::MAXW-1:0] RowFull =
      gfm_pkg::xPowMod(WIDTH, gfm_pkg::MAXW'(POLY), WIDTH + j);
    assign qRow[j] = RowFull[WIDTH-1:0];
  end

  always_comb begin
    prodOut = lowVec;
    for (int j = 0; j < WIDTH - 1; j++) begin
      if (highVec[j]) prodOut = prodOut ^ qRow[j];
    end
  end

  always_comb begin
    if (!$isunknown({lowVec, highVec, prodOut}) && highVec == '0) begin
      // R4
      no_fold_chk: assert (prodOut == lowVec);
    end
  end
endmodule

// File: rtl/gfmul_pb.sv
module gfmul_pb #(
  parameter int              WIDTH = 8,
  parameter logic [WIDTH-1:0] POLY = 8'h1B
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] prodOut,
  output logic [WIDTH-1:0] lowVec,
  output logic [WIDTH-2:0] highVec
);
  initial begin
    width_param_chk: assert (WIDTH >= 2 && WIDTH <= gfm_pkg::MAXW);
  end

  gfm_inner #(.WIDTH(WIDTH)) u_inner (
    .opA(opA), .opB(opB), .lowVec(lowVec), .highVec(highVec)
  );

  gfm_reduce #(.WIDTH(WIDTH), .POLY(POLY)) u_reduce (
    .lowVec(lowVec), .highVec(highVec), .prodOut(prodOut)
  );

  always_comb begin
    if (!$isunknown({opA, opB, prodOut, lowVec, highVec})) begin
      if (opA == '0 || opB == '0) begin
        // R5
        zero_operand_chk: assert (prodOut == '0 && lowVec == '0 && highVec == '0);
      end
      if (opA == WIDTH'(1)) begin
        // R6
        identity_chk: assert (prodOut == opB);
      end
    end
  end
endmodule

// File: tb/gfmul_pb_bench.sv
module gfmul_pb_bench;
  localparam int W = 8;
  localparam logic [W-1:0] PL = 8'h1B;
  localparam int WS = 3;
  localparam logic [WS-1:0] PLS = 3'b011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] opA = '0, opB = '0, prodOut, lowVec;
  logic [W-2:0] highVec;
  logic [WS-1:0] sA = '0, sB = '0, sProd, sLow;
  logic [WS-2:0] sHigh;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gfmul_pb #(.WIDTH(W), .POLY(PL)) u_gfmul_pb (
    .opA(opA), .opB(opB), .prodOut(prodOut), .lowVec(lowVec), .highVec(highVec)
  );
  gfmul_pb #(.WIDTH(WS), .POLY(PLS)) u_gfmul_pb_small (
    .opA(sA), .opB(sB), .prodOut(sProd), .lowVec(sLow), .highVec(sHigh)
  );

  function automatic int clMul(int a, int b, int m);
    int r = 0;
    for (int i = 0; i < m; i++) if ((b >> i) & 1) r = r ^ (a << i);
    return r;
  endfunction

  function automatic int refMul(int a, int b, int m, int poly);
    int r = 0;
    int aa = a;
    for (int i = 0; i < m; i++) begin
      if ((b >> i) & 1) r = r ^ aa;
      aa = aa << 1;
      if ((aa >> m) & 1) aa = aa ^ ((1 << m) | poly);
    end
    return r;
  endfunction

  function automatic int foldRef(int low, int high, int m, int poly);
    int r = low;
    for (int j = 0; j < m - 1; j++)
      if ((high >> j) & 1) r = r ^ refMul(1 << (m - 1), 2 << j, m, poly);
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(int a, int b);
    @(posedge clk);
    #2;
    opA = W'(a);
    opB = W'(b);
    @(negedge clk);
  endtask

  initial begin
    int full;
    int save;
    int sf;
    int eS;
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // reset state with zero operands (R5)
    check(prodOut == '0 && lowVec == '0 && highVec == '0, "R5 reset", int'(prodOut), 0);

    // exhaustive sweep at WIDTH 8
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        apply(a, b);
        full = clMul(a, b, W);
        check(int'(prodOut) == refMul(a, b, W, int'(PL)), "R1", int'(prodOut), refMul(a, b, W, int'(PL)));
        check(int'(lowVec) == (full & ((1 << W) - 1)), "R2", int'(lowVec), full & ((1 << W) - 1));
        check(int'(highVec) == (full >> W), "R3", int'(highVec), full >> W);
        check(int'(prodOut) == foldRef(int'(lowVec), int'(highVec), W, int'(PL)), "R4",
              int'(prodOut), foldRef(int'(lowVec), int'(highVec), W, int'(PL)));
        if (a == 0 || b == 0)
          check(prodOut == '0 && highVec == '0, "R5", int'(prodOut), 0);
        if (a == 1)
          check(int'(prodOut) == b && highVec == '0, "R6", int'(prodOut), b);
      end
    end

    // operand order (R8)
    for (int k = 0; k < 6; k++) begin
      int x = (37 * k + 11) & 8'hFF;
      int y = (91 * k + 200) & 8'hFF;
      apply(x, y);
      save = {int'(prodOut), int'(lowVec), int'(highVec)};
      apply(y, x);
      sf = {int'(prodOut), int'(lowVec), int'(highVec)};
      check(sf == save, "R8", sf, save);
    end

    // settles with no clock edge (R7)
    @(posedge clk);
    #2 opA = 8'hC3; opB = 8'h5A;
    #1 check(int'(prodOut) == refMul(8'hC3, 8'h5A, W, int'(PL)), "R7", int'(prodOut), refMul(8'hC3, 8'h5A, W, int'(PL)));
    #1 opB = 8'h01;
    #1 check(prodOut == 8'hC3, "R7", int'(prodOut), 8'hC3);

    // small field, all pairs (R9, R1)
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        @(posedge clk);
        #2 sA = WS'(a); sB = WS'(b);
        @(negedge clk);
        eS = refMul(a, b, WS, int'(PLS));
        check(int'(sProd) == eS, "R1 small", int'(sProd), eS);
        check(sProd[2] == (sLow[2] ^ sHigh[1]), "R9 c2", int'(sProd[2]), int'(sLow[2] ^ sHigh[1]));
        check(sProd[1] == (sLow[1] ^ sHigh[0] ^ sHigh[1]), "R9 c1", int'(sProd[1]), int'(sLow[1] ^ sHigh[0] ^ sHigh[1]));
        check(sProd[0] == (sLow[0] ^ sHigh[0]), "R9 c0", int'(sProd[0]), int'(sLow[0] ^ sHigh[0]));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule